// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block forms the byte handed back on a read while the embedded program or erase engine of a flash array is active, while erase is suspended, or after the engine reports a failure. It drives the polling, toggle, error and erase-timer bits of the status byte from the engine state, the data byte being programmed, a bitmap of the blocks selected for erase and the block index of the read address. Outside status reporting it passes the array byte from the read path straight through. It also produces a ready/busy flag.

The two toggle bits are held in flip-flops that advance only on the read strobe, so that software polling in a loop sees a new value on each read, and clock cycles without a read leave the toggle phase as it was. An erase whose selected blocks are all protected is reported as busy for a parameterised number of cycles, after which the block reports idle behaviour with no error flagged.

Top module: `pe_status_gen`

## Requirements
- R1: With engine state PROG (code 1) the byte is {~prog_data[7], tog6, err, 0, 0, 1, 0, 0} (bit 7 down to bit 0) and `ready_o` is 0.
- R2: With state ERASE (code 2) bit 7 is 0, bit 3 is 0 while `etimer_run` is 1 and 1 otherwise, bit 2 is 1 when the read block is not selected in `erase_map`, and `ready_o` is 0.
- R3: Bit 6 inverts once for each cycle with `rd_stb` high in states PROG, ERASE and FAIL, and holds its value across cycles without `rd_stb`.
- R4: Bit 2 inverts once for each strobed read whose block is selected in `erase_map`, in states ERASE and SUSP (code 3); strobed reads from unselected blocks leave its phase unchanged.
- R5: With state SUSP a read from a selected block gives {1, 1, err, 0, 1, tog2, 0, 0}; a read from an unselected block gives `array_data`; `ready_o` is 1.
- R6: With state IDLE (code 0, or any unused code) the byte equals `array_data` and `ready_o` is 1, so two successive reads match.
- R7: Bit 5 is 1 in state FAIL (code 4, where the byte is {~prog_data[7], tog6, 1, 0, 0, 1, 0, 0} and `ready_o` is 1); the internal error flag is then set one clock later, is set one clock after entering PROG if `prog_data` has a 1 where `array_data` has a 0, is cleared one clock after a clean PROG entry or an ERASE entered from IDLE, and is cleared by `rr_clear`.
- R8: In ERASE with `prot_all` high the erase status is reported with `ready_o` 0 for PROT_CYC clocks; from then on the byte equals `array_data`, `ready_o` is 1 and bit 5 stays 0.
- R9: Bits 4, 1 and 0 are 0 whenever a status byte is reported.
- R10: After reset both toggle bits and the error flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_state | input | 3 | Engine state: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 failed |
| prog_data | input | 8 | Byte being programmed |
| array_data | input | 8 | Array byte at the read (or program) address |
| erase_map | input | NBLK | One bit per block selected for erase |
| rd_blk | input | BLK_W | Block index of the read address |
| rd_stb | input | 1 | One pulse per read access |
| etimer_run | input | 1 | Multi-block erase timeout running |
| prot_all | input | 1 | All blocks selected for erase are protected |
| rr_clear | input | 1 | Read/reset instruction seen; clears the error flag |
| status_o | output | 8 | Byte returned on a read |
| ready_o | output | 1 | 1 ready, 0 busy |

## Verification
The hardest situation to reach is the toggle phase of bit 2 surviving a detour: a strobed read from an unselected block, and a move from erase into suspend, must leave the phase exactly where it was. The stimulus records bit 2, issues strobed reads on selected and unselected blocks in both states, then returns to a selected block and compares against the recorded phase. The protected-erase window is reached by holding `prot_all` through an erase and sampling one clock before and at the end of the window.

// File: rtl/pe_status_pkg.sv
// Shared state encoding for the program/erase status generator.
// Assumes the engine drives one of these codes; other codes read as idle.
package pe_status_pkg;
    typedef enum logic [2:0] {
        PE_IDLE  = 3'd0,
        PE_PROG  = 3'd1,
        PE_ERASE = 3'd2,
        PE_SUSP  = 3'd3,
        PE_FAIL  = 3'd4
    } pe_state_e;
endpackage

// File: rtl/pe_toggle_bit.sv
// One toggle flip-flop that advances only when adv is high.
// Assumes adv is already qualified by the read strobe.
module pe_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic q
);
    // Flip the phase on each qualified read.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (adv) q <= ~q;
    end
endmodule

// File: rtl/pe_err_flag.sv
// Sticky error flag behind status bit 5.
// Assumes prog_data and array_data are valid in the cycle the engine enters program.
module pe_err_flag
    import pe_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pe_state_e  st,
    input  logic [7:0] prog_data,
    input  logic [7:0] array_data,
    input  logic       rr_clear,
    output logic       err_o
);
    pe_state_e st_q;
    logic      prog_entry;
    logic      erase_new;
    logic      one_over_zero;

    assign prog_entry    = (st == PE_PROG) && (st_q != PE_PROG);
    assign erase_new     = (st == PE_ERASE) && (st_q == PE_IDLE);
    assign one_over_zero = |(prog_data & ~array_data);

    // Remember the previous engine state to find operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PE_IDLE;
        else        st_q <= st;
    end

    // Set on failure or an illegal program, clear on reset instruction or clean start.
    always_ff @(posedge clk) begin
        if (!rst_n)            err_o <= 1'b0;
        else if (rr_clear)     err_o <= 1'b0;
        else if (st == PE_FAIL) err_o <= 1'b1;
        else if (prog_entry)   err_o <= one_over_zero;
        else if (erase_new)    err_o <= 1'b0;
    end
endmodule

// File: rtl/pe_prot_timer.sv
// Counts the busy window of an erase whose selected blocks are all protected.
// Assumes erase_on stays high for the whole erase; the count restarts when it drops.
module pe_prot_timer #(
    parameter int PROT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_on,
    input  logic prot_all,
    output logic expired_o
);
    localparam int CNT_W = $clog2(PROT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PROT_CYC);

    logic [CNT_W-1:0] cnt;

    // Count up to the limit while a fully protected erase is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || !erase_on)           cnt <= '0;
        else if (prot_all && cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign expired_o = erase_on && prot_all && (cnt == LIMIT);
endmodule

// File: rtl/pe_status_gen.sv
// Status byte and ready/busy generator for an embedded program/erase engine.
// Assumes rd_stb marks one read per pulse and rd_blk is the block of that read.
module pe_status_gen
    import pe_status_pkg::*;
#(
    parameter int NBLK     = 19,
    parameter int PROT_CYC = 40,
    parameter int BLK_W    = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      eng_state,
    input  logic [7:0]      prog_data,
    input  logic [7:0]      array_data,
    input  logic [NBLK-1:0] erase_map,
    input  logic [BLK_W-1:0] rd_blk,
    input  logic            rd_stb,
    input  logic            etimer_run,
    input  logic            prot_all,
    input  logic            rr_clear,
    output logic [7:0]      status_o,
    output logic            ready_o
);
    localparam int NTOG = 2;
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NBLK - 1);

    pe_state_e       st;
    logic            in_blk;
    logic            expired;
    logic            err;
    logic            erase_live;
    logic [NTOG-1:0] tog_adv;
    logic [NTOG-1:0] tog_q;

    assign st         = pe_state_e'(eng_state);
    assign in_blk     = (rd_blk <= LAST_BLK) && erase_map[rd_blk];
    assign erase_live = (st == PE_ERASE) && !expired;

    // Index 1 drives bit 6, index 0 drives bit 2.
    assign tog_adv[1] = rd_stb && ((st == PE_PROG) || (st == PE_FAIL) || erase_live);
    assign tog_adv[0] = rd_stb && in_blk && (erase_live || (st == PE_SUSP));

    generate
        for (genvar g = 0; g < NTOG; g++) begin : g_tog
            pe_toggle_bit tog_i (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (tog_adv[g]),
                .q     (tog_q[g])
            );
        end
    endgenerate

    pe_err_flag err_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .st         (st),
        .prog_data  (prog_data),
        .array_data (array_data),
        .rr_clear   (rr_clear),
        .err_o      (err)
    );

    pe_prot_timer #(.PROT_CYC(PROT_CYC)) prot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_on  (st == PE_ERASE),
        .prot_all  (prot_all),
        .expired_o (expired)
    );

    // Select the reported byte and ready flag from the engine state.
    always_comb begin
        status_o = array_data;
        ready_o  = 1'b1;
        case (st)
            PE_PROG: begin
                status_o = {~prog_data[7], tog_q[1], err, 1'b0, 1'b0, 1'b1, 2'b00};
                ready_o  = 1'b0;
            end
            PE_ERASE: begin
                if (!expired) begin
                    status_o = {1'b0, tog_q[1], err, 1'b0, ~etimer_run,
                                in_blk ? tog_q[0] : 1'b1, 2'b00};
                    ready_o  = 1'b0;
                end
            end
            PE_SUSP: begin
                if (in_blk)
                    status_o = {2'b11, err, 1'b0, 1'b1, tog_q[0], 2'b00};
            end
            PE_FAIL: begin
                status_o = {~prog_data[7], tog_q[1], 1'b1, 1'b0, 1'b0, 1'b1, 2'b00};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pe_status_chk.sv
// Property checker for pe_status_gen, attached by bind.
// Assumes the same parameters as the design instance.
module pe_status_chk
    import pe_status_pkg::*;
#(
    parameter int NBLK  = 19,
    parameter int BLK_W = $clog2(NBLK)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      eng_state,
    input logic [7:0]      prog_data,
    input logic [NBLK-1:0] erase_map,
    input logic [BLK_W-1:0] rd_blk,
    input logic            rd_stb,
    input logic [7:0]      status_o,
    input logic            ready_o
);
    logic stat_mode;
    assign stat_mode = (eng_state == PE_PROG) || (eng_state == PE_FAIL);

    p_prog_poll_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == PE_PROG) |-> (status_o[7] == ~prog_data[7] && !ready_o));

    p_tgl_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == PE_PROG && rd_stb) |=>
        (eng_state != PE_PROG || status_o[6] != $past(status_o[6])));

    p_tgl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == PE_PROG && !rd_stb) |=>
        (eng_state != PE_PROG || $stable(status_o[6])));

    p_susp_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == PE_SUSP && rd_blk < BLK_W'(NBLK) && erase_map[rd_blk]) |->
        (status_o[7:6] == 2'b11 && ready_o));

    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_mode |-> (status_o[4] == 1'b0 && status_o[1:0] == 2'b00));
endmodule

bind pe_status_gen pe_status_chk #(.NBLK(NBLK), .BLK_W(BLK_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_state (eng_state),
    .prog_data (prog_data),
    .erase_map (erase_map),
    .rd_blk    (rd_blk),
    .rd_stb    (rd_stb),
    .status_o  (status_o),
    .ready_o   (ready_o)
);

// File: tb/pe_status_gen_tb_top.sv
`timescale 1ns/1ps
module pe_status_gen_tb_top;
    import pe_status_pkg::*;

    localparam int NBLK     = 19;
    localparam int PROT_CYC = 40;
    localparam int BLK_W    = $clog2(NBLK);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      eng_state = 3'd0;
    logic [7:0]      prog_data = 8'hFF;
    logic [7:0]      array_data = 8'hFF;
    logic [NBLK-1:0] erase_map = '0;
    logic [BLK_W-1:0] rd_blk = '0;
    logic            rd_stb = 1'b0;
    logic            etimer_run = 1'b0;
    logic            prot_all = 1'b0;
    logic            rr_clear = 1'b0;
    logic [7:0]      status_o;
    logic            ready_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pe_status_gen #(.NBLK(NBLK), .PROT_CYC(PROT_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .eng_state(eng_state), .prog_data(prog_data),
        .array_data(array_data), .erase_map(erase_map), .rd_blk(rd_blk),
        .rd_stb(rd_stb), .etimer_run(etimer_run), .prot_all(prot_all),
        .rr_clear(rr_clear), .status_o(status_o), .ready_o(ready_o)
    );

    typedef struct packed {
        logic [2:0] st;
        logic [7:0] pd;
        logic [4:0] blk;
        logic       etim;
        logic [7:0] arr;
        logic [7:0] exp;
        logic [7:0] mask;
        logic       rdy;
    } vec_t;

    // Blocks 3 and 5 are selected for erase throughout.
    localparam vec_t VEC [9] = '{
        '{3'd0, 8'h00, 5'd0, 1'b0, 8'h3C, 8'h3C, 8'hFF, 1'b1},  // R6 idle
        '{3'd1, 8'h5A, 5'd0, 1'b0, 8'hFF, 8'h84, 8'hBF, 1'b0},  // R1 program, bit7 clear
        '{3'd1, 8'hA5, 5'd0, 1'b0, 8'hFF, 8'h04, 8'hBF, 1'b0},  // R1 program, bit7 set
        '{3'd2, 8'h00, 5'd1, 1'b1, 8'hFF, 8'h04, 8'hBF, 1'b0},  // R2 timer running
        '{3'd2, 8'h00, 5'd1, 1'b0, 8'hFF, 8'h0C, 8'hBF, 1'b0},  // R2 timer done
        '{3'd2, 8'h00, 5'd3, 1'b0, 8'hFF, 8'h08, 8'hBB, 1'b0},  // R2 selected block
        '{3'd3, 8'h00, 5'd5, 1'b0, 8'h77, 8'hC8, 8'hFB, 1'b1},  // R5 suspend selected
        '{3'd3, 8'h00, 5'd2, 1'b0, 8'h77, 8'h77, 8'hFF, 1'b1},  // R5 suspend other
        '{3'd0, 8'h00, 5'd0, 1'b0, 8'h00, 8'h00, 8'hFF, 1'b1}   // R6 idle
    };

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp, logic [7:0] mask);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            errors++;
            $display("FAIL %s: status actual %02h expected %02h (mask %02h)", tag, act, exp, mask);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive state and data at a falling edge, let one rising edge pass.
    task automatic apply(logic [2:0] st, logic [7:0] pd, logic [4:0] blk, logic etim, logic [7:0] arr);
        @(negedge clk);
        eng_state = st; prog_data = pd; rd_blk = blk; etimer_run = etim; array_data = arr;
        @(negedge clk);
    endtask

    // One strobed read covering one rising edge.
    task automatic strobe();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic b;
        erase_map = '0;
        erase_map[3] = 1'b1;
        erase_map[5] = 1'b1;

        // R10: reset state, seen through a program read during reset.
        eng_state = PE_PROG; prog_data = 8'hFF; array_data = 8'hFF;
        repeat (3) @(negedge clk);
        chk8("R10 toggles and error clear", status_o, 8'h04, 8'hFF);
        rst_n = 1'b1;
        apply(PE_IDLE, 8'h00, 5'd0, 1'b0, 8'hFF);

        // Table walk over static decode.
        foreach (VEC[i]) begin
            apply(VEC[i].st, VEC[i].pd, VEC[i].blk, VEC[i].etim, VEC[i].arr);
            chk8($sformatf("vector %0d R1/R2/R5/R6/R9", i), status_o, VEC[i].exp, VEC[i].mask);
            chk1($sformatf("vector %0d ready R1/R2/R5/R6", i), ready_o, VEC[i].rdy);
        end

        // R3: bit 6 flips per read, holds without reads.
        apply(PE_PROG, 8'h00, 5'd0, 1'b0, 8'hFF);
        b = status_o[6];
        strobe();
        chk1("R3 first read flips", status_o[6], ~b);
        strobe();
        chk1("R3 second read flips back", status_o[6], b);
        repeat (5) @(negedge clk);
        chk1("R3 no read holds", status_o[6], b);

        // R6: idle, two successive reads match.
        apply(PE_IDLE, 8'h00, 5'd0, 1'b0, 8'h9E);
        b = status_o[6];
        strobe();
        chk8("R6 successive reads match", status_o, 8'h9E, 8'hFF);
        chk1("R6 bit6 unchanged", status_o[6], b);

        // R4: bit 2 phase on selected and unselected reads, erase then suspend.
        apply(PE_ERASE, 8'h00, 5'd3, 1'b0, 8'hFF);
        b = status_o[2];
        strobe();
        chk1("R4 erase selected read flips", status_o[2], ~b);
        @(negedge clk); rd_blk = 5'd1;
        strobe();
        chk1("R4 unselected block reads one", status_o[2], 1'b1);
        @(negedge clk); rd_blk = 5'd3;
        @(negedge clk);
        chk1("R4 phase kept across unselected read", status_o[2], ~b);
        apply(PE_SUSP, 8'h00, 5'd3, 1'b0, 8'hFF);
        chk1("R4 phase kept into suspend", status_o[2], ~b);
        strobe();
        chk1("R4 suspend selected read flips", status_o[2], b);

        // R7: error flag paths.
        apply(PE_IDLE, 8'h00, 5'd0, 1'b0, 8'hFF);
        apply(PE_PROG, 8'hFF, 5'd0, 1'b0, 8'h0F);
        chk1("R7 one over zero sets bit5", status_o[5], 1'b1);
        apply(PE_IDLE, 8'h00, 5'd0, 1'b0, 8'hFF);
        apply(PE_PROG, 8'h0F, 5'd0, 1'b0, 8'hFF);
        chk1("R7 clean program clears bit5", status_o[5], 1'b0);
        apply(PE_FAIL, 8'h00, 5'd0, 1'b0, 8'hFF);
        chk8("R7 fail byte", status_o, 8'hA4, 8'hBF);
        chk1("R7 fail ready", ready_o, 1'b1);
        apply(PE_SUSP, 8'h00, 5'd3, 1'b0, 8'hFF);
        chk1("R7 flag held after fail", status_o[5], 1'b1);
        rr_clear = 1'b1;
        @(negedge clk);
        rr_clear = 1'b0;
        chk1("R7 read/reset clears bit5", status_o[5], 1'b0);

        // R8: fully protected erase window.
        apply(PE_IDLE, 8'h00, 5'd3, 1'b0, 8'h5D);
        @(negedge clk);
        eng_state = PE_ERASE; prot_all = 1'b1;
        for (int i = 1; i < PROT_CYC; i++) @(negedge clk);
        chk1("R8 busy at last window cycle", ready_o, 1'b0);
        chk1("R8 bit7 zero in window", status_o[7], 1'b0);
        @(negedge clk);
        chk1("R8 ready after window", ready_o, 1'b1);
        chk8("R8 array data after window", status_o, 8'h5D, 8'hFF);
        prot_all = 1'b0;
        apply(PE_IDLE, 8'h00, 5'd3, 1'b0, 8'hFF);
        apply(PE_SUSP, 8'h00, 5'd3, 1'b0, 8'hFF);
        chk1("R8 no error after window", status_o[5], 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule